// File: doc/BRIEF.md
# Protection Descriptor Lookup Checker

This block decides whether a single memory access is permitted. Each access presents an address, a size, a write flag, an instruction/data selector, a supervisor flag and a flag that marks an access from the secondary address generator. The block returns a result code within the same cycle. To build that code it compares the address against a bank of protection descriptors for the selected side and applies a fixed set of region rules. The instruction side and the data side each have their own bank and their own control word.

Each descriptor holds a base address and an attribute word. A descriptor covers a span of 1 KB, 4 KB, 1 MB or 4 MB starting at its base. A permission fault, an overlap of two descriptors, a missing descriptor or a misaligned address is reported as a result code. The same event also loads the fault status and fault address registers of the side at the next clock edge. Software programs the descriptors and the control words through a write-only register port. The fault registers can only be read, through the output ports.

Top module: `prot_lookup_checker`

## Requirements
- R1: An access whose address has a nonzero bit where (bytes-1) is nonzero returns the misaligned code before any other check. Bytes = 1 << acc_size, so acc_size 0..3 means 1, 2, 4 or 8 bytes.
- R2: An entry matches when its valid bit (attribute bit 0) is set and base <= address < base + span. Attribute bits 17:16 pick the span: 0 gives 1 KB, 1 gives 4 KB, 2 gives 1 MB and 3 gives 4 MB.
- R3: On a write, a matching entry fails in three cases. A user access needs the user-write bit (attribute bit 3). A supervisor access needs the supervisor-write bit (bit 4). The entry also fails when, of cacheable (bit 12), write-through (bit 14) and dirty (bit 7), only cacheable is set.
- R4: On a read, a user access needs the user-read bit (attribute bit 2). Supervisor reads pass every entry.
- R5: With descriptors enabled, two or more matches give multiple-hit. One match with a permission failure gives violation. Otherwise the region rules decide, and zero matches with no rule give miss. Result codes: 0 ok; data side 1 miss, 2 violation, 3 multiple-hit, 4 misaligned; instruction side 5, 6, 7, 8 in the same order; 9 hardware error.
- R6: Each side's control word resets to 0x00000001. When its bit 0 is clear the descriptors are ignored, the access counts as a single match, and only the region rules can produce a fault.
- R7: At or above SYS_BASE (default 0xFFC00000), an instruction fetch is a miss. A data access there is ok only in supervisor mode without the secondary flag, and is a violation otherwise.
- R8: Below SYS_BASE, for addresses 0xFFxxxxxx, fetches from the megabyte 0xFFA00000 are ok and fetches elsewhere are violations. Data accesses to 0xFFA00000 give the hardware-error code, and data accesses elsewhere in that region are ok.
- R9: A fault loads the side's fault address with the access address at the next edge. It loads the fault status with bit 19 = miss, 18 = secondary flag, 17 = supervisor, 16 = write, and bits 15:0 = the mask of matching entries (zero while descriptors are disabled).
- R10: A data-side fault also loads the instruction fault address with acc_pc and the instruction fault status with only bit 17 = supervisor.
- R11: Fault registers reset to zero. Accesses that return ok or hardware error leave all four fault registers unchanged.
- R12: A register write with cfg_sel 0 loads the control word, 1 the entry base and 2 the entry attribute of side cfg_side (0 data, 1 instruction). cfg_sel 3 has no effect. Descriptors reset to zero, so they are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_side | input | 1 | 0 data bank, 1 instruction bank |
| cfg_sel | input | 2 | 0 control, 1 base, 2 attribute, 3 none |
| cfg_idx | input | 4 | Entry index |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | log2 of access bytes |
| acc_write | input | 1 | Write access |
| acc_inst | input | 1 | Instruction fetch |
| acc_supv | input | 1 | Supervisor mode |
| acc_sec | input | 1 | Secondary address generator |
| acc_pc | input | 32 | Current program counter |
| res_code | output | 4 | Result code (combinational) |
| d_fault_status | output | 32 | Data fault status |
| d_fault_addr | output | 32 | Data fault address |
| i_fault_status | output | 32 | Instruction fault status |
| i_fault_addr | output | 32 | Instruction fault address |

## Verification
The assertions check several relations on every cycle. Misalignment always wins. A fetch from the system region with no descriptor conflict is a miss. A programmed base is held. A logged fault carries the access address and the program counter. A hardware error leaves the fault registers untouched. The bench sweeps cover the behaviours that need a chosen stimulus. These are every attribute combination against write and mode, the span edges of all four page sizes, overlapping entries, and the region rules with descriptors both enabled and disabled. Each result is compared with a model built from the requirements.

// File: rtl/plc_pkg.sv
package plc_pkg;
    typedef enum logic [2:0] {
        IMP_NONE, IMP_OK, IMP_MISS, IMP_VIOL, IMP_HWERR
    } imp_t;

    typedef enum logic [2:0] {
        K_OK, K_MISS, K_VIOL, K_MHIT, K_MISALIGN, K_HWERR
    } kind_t;

    localparam logic [3:0] RC_OK          = 4'd0;
    localparam logic [3:0] RC_D_MISS      = 4'd1;
    localparam logic [3:0] RC_D_VIOL      = 4'd2;
    localparam logic [3:0] RC_D_MHIT      = 4'd3;
    localparam logic [3:0] RC_D_MISALIGN  = 4'd4;
    localparam logic [3:0] RC_I_MISS      = 4'd5;
    localparam logic [3:0] RC_I_VIOL      = 4'd6;
    localparam logic [3:0] RC_I_MHIT      = 4'd7;
    localparam logic [3:0] RC_I_MISALIGN  = 4'd8;
    localparam logic [3:0] RC_HWERR       = 4'd9;

    localparam int ATTR_VALID = 0;
    localparam int ATTR_UR    = 2;
    localparam int ATTR_UW    = 3;
    localparam int ATTR_SW    = 4;
    localparam int ATTR_DIRTY = 7;
    localparam int ATTR_CACHE = 12;
    localparam int ATTR_WT    = 14;
    localparam int ATTR_PG_LO = 16;
endpackage

// File: rtl/plc_desc_bank.sv
module plc_desc_bank #(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [IW-1:0] cfg_idx,
    input  logic [31:0]   cfg_wdata,
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          supv,
    output logic          enable,
    output logic [N-1:0]  hit_mask,
    output logic          perm_fail
);
    import plc_pkg::*;

    logic [31:0]   ctrl_q;
    logic [N-1:0]  viol_vec;
    logic [AW-1:0] base_q [N];
    logic [31:0]   attr_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 32'h0000_0001;
        else if (cfg_we && cfg_sel == 2'd0)
            ctrl_q <= cfg_wdata;
    end

    assign enable = ctrl_q[0];

    for (genvar e = 0; e < N; e++) begin : g_ent
        logic [AW:0] span;
        logic [AW:0] top;
        logic        in_rng;
        logic        wr_bad;
        logic        rd_bad;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[e] <= '0;
                attr_q[e] <= '0;
            end else if (cfg_we && cfg_idx == IW'(e)) begin
                if (cfg_sel == 2'd1) base_q[e] <= cfg_wdata[AW-1:0];
                if (cfg_sel == 2'd2) attr_q[e] <= cfg_wdata;
            end
        end

        always_comb begin
            unique case (attr_q[e][ATTR_PG_LO+1:ATTR_PG_LO])
                2'd0:    span = (AW+1)'(32'h0000_0400);
                2'd1:    span = (AW+1)'(32'h0000_1000);
                2'd2:    span = (AW+1)'(32'h0010_0000);
                default: span = (AW+1)'(32'h0040_0000);
            endcase
        end

        assign top    = {1'b0, base_q[e]} + span;
        assign in_rng = (addr >= base_q[e]) && ({1'b0, addr} < top);
        assign hit_mask[e] = attr_q[e][ATTR_VALID] && in_rng;

        assign wr_bad = (!supv && !attr_q[e][ATTR_UW])
                     || (supv && !attr_q[e][ATTR_SW])
                     || (attr_q[e][ATTR_CACHE] && !attr_q[e][ATTR_WT]
                         && !attr_q[e][ATTR_DIRTY]);
        assign rd_bad = !supv && !attr_q[e][ATTR_UR];
        assign viol_vec[e] = write ? wr_bad : rd_bad;

        // R12
        base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == 2'd1 && cfg_idx == IW'(e))
            |=> base_q[e] == $past(cfg_wdata[AW-1:0]));

        // R2
        inval_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !attr_q[e][ATTR_VALID] |-> !hit_mask[e]);
    end

    assign perm_fail = |(hit_mask & viol_vec);
endmodule

// File: rtl/plc_implicit.sv
module plc_implicit #(
    parameter int          AW       = 32,
    parameter logic [31:0] SYS_BASE = 32'hFFC0_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          inst,
    input  logic          supv,
    input  logic          sec,
    output plc_pkg::imp_t imp
);
    import plc_pkg::*;

    localparam logic [7:0]  ONCHIP_TOP = 8'hFF;
    localparam logic [11:0] CODE_MB    = 12'hFFA;

    logic in_sys;
    logic in_onchip;
    logic in_code_mb;

    assign in_sys     = addr >= AW'(SYS_BASE);
    assign in_onchip  = addr[AW-1:AW-8] == ONCHIP_TOP;
    assign in_code_mb = addr[AW-1:AW-12] == CODE_MB;

    always_comb begin
        imp = IMP_NONE;
        if (in_sys) begin
            if (inst)              imp = IMP_MISS;
            else if (!supv || sec) imp = IMP_VIOL;
            else                   imp = IMP_OK;
        end else if (in_onchip) begin
            if (inst) imp = in_code_mb ? IMP_OK : IMP_VIOL;
            else      imp = in_code_mb ? IMP_HWERR : IMP_OK;
        end
    end

    // R7
    sys_user_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sys && !inst && !supv) |-> imp == IMP_VIOL);

    // R8
    code_data_hwerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_code_mb && !in_sys && !inst) |-> imp == IMP_HWERR);
endmodule

// File: rtl/plc_fault_log.sv
module plc_fault_log #(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          log_en,
    input  logic          inst,
    input  logic          miss,
    input  logic          write,
    input  logic          supv,
    input  logic          sec,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   pc,
    input  logic [N-1:0]  mask,
    output logic [31:0]   d_status,
    output logic [31:0]   d_addr,
    output logic [31:0]   i_status,
    output logic [31:0]   i_addr
);
    logic [31:0] stat_word;

    assign stat_word = {12'd0, miss, sec, supv, write, 16'(mask)};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_status <= '0;
            d_addr   <= '0;
            i_status <= '0;
            i_addr   <= '0;
        end else if (log_en) begin
            if (inst) begin
                i_status <= stat_word;
                i_addr   <= 32'(addr);
            end else begin
                d_status <= stat_word;
                d_addr   <= 32'(addr);
                i_status <= {14'd0, supv, 17'd0};
                i_addr   <= pc;
            end
        end
    end

    // R10
    pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && !inst) |=> i_addr == $past(pc));

    // R9
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && !inst) |=> d_addr == $past(32'(addr)));

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !log_en |=> ($stable(d_status) && $stable(i_status)
                     && $stable(d_addr) && $stable(i_addr)));
endmodule

// File: rtl/prot_lookup_checker.sv
module prot_lookup_checker #(
    parameter int          N        = 16,
    parameter logic [31:0] SYS_BASE = 32'hFFC0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_side,
    input  logic [1:0]  cfg_sel,
    input  logic [3:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_size,
    input  logic        acc_write,
    input  logic        acc_inst,
    input  logic        acc_supv,
    input  logic        acc_sec,
    input  logic [31:0] acc_pc,
    output logic [3:0]  res_code,
    output logic [31:0] d_fault_status,
    output logic [31:0] d_fault_addr,
    output logic [31:0] i_fault_status,
    output logic [31:0] i_fault_addr
);
    import plc_pkg::*;

    localparam int AW = 32;
    localparam int IW = $clog2(N);

    logic [N-1:0] side_mask [2];
    logic [1:0]   side_en;
    logic [1:0]   side_pfail;
    logic [N-1:0] mask_eff;
    logic         en_sel;
    logic         pfail_sel;
    logic [2:0]   low_mask;
    logic         misalign;
    int unsigned  nhits;
    imp_t         imp;
    kind_t        kind;
    logic         log_en;

    for (genvar s = 0; s < 2; s++) begin : g_side
        plc_desc_bank #(.N(N), .AW(AW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && (cfg_side == s[0])),
            .cfg_sel   (cfg_sel),
            .cfg_idx   (cfg_idx[IW-1:0]),
            .cfg_wdata (cfg_wdata),
            .addr      (acc_addr),
            .write     (acc_write),
            .supv      (acc_supv),
            .enable    (side_en[s]),
            .hit_mask  (side_mask[s]),
            .perm_fail (side_pfail[s])
        );
    end

    plc_implicit #(.AW(AW), .SYS_BASE(SYS_BASE)) u_imp (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (acc_addr),
        .inst  (acc_inst),
        .supv  (acc_supv),
        .sec   (acc_sec),
        .imp   (imp)
    );

    assign en_sel    = side_en[acc_inst];
    assign pfail_sel = side_pfail[acc_inst];
    assign mask_eff  = en_sel ? side_mask[acc_inst] : '0;
    assign nhits     = $countones(mask_eff);
    assign low_mask  = 3'((4'd1 << acc_size) - 4'd1);
    assign misalign  = |(acc_addr[2:0] & low_mask);

    always_comb begin
        kind = K_OK;
        if (acc_valid) begin
            if (misalign)
                kind = K_MISALIGN;
            else if (en_sel && nhits >= 2)
                kind = K_MHIT;
            else if (en_sel && pfail_sel)
                kind = K_VIOL;
            else begin
                unique case (imp)
                    IMP_OK:    kind = K_OK;
                    IMP_MISS:  kind = K_MISS;
                    IMP_VIOL:  kind = K_VIOL;
                    IMP_HWERR: kind = K_HWERR;
                    default:   kind = (!en_sel || nhits == 1) ? K_OK : K_MISS;
                endcase
            end
        end
    end

    always_comb begin
        unique case (kind)
            K_MISS:     res_code = acc_inst ? RC_I_MISS     : RC_D_MISS;
            K_VIOL:     res_code = acc_inst ? RC_I_VIOL     : RC_D_VIOL;
            K_MHIT:     res_code = acc_inst ? RC_I_MHIT     : RC_D_MHIT;
            K_MISALIGN: res_code = acc_inst ? RC_I_MISALIGN : RC_D_MISALIGN;
            K_HWERR:    res_code = RC_HWERR;
            default:    res_code = RC_OK;
        endcase
    end

    assign log_en = (kind != K_OK) && (kind != K_HWERR);

    plc_fault_log #(.N(N), .AW(AW)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .log_en   (log_en),
        .inst     (acc_inst),
        .miss     (kind == K_MISS),
        .write    (acc_write),
        .supv     (acc_supv),
        .sec      (acc_sec),
        .addr     (acc_addr),
        .pc       (acc_pc),
        .mask     (mask_eff),
        .d_status (d_fault_status),
        .d_addr   (d_fault_addr),
        .i_status (i_fault_status),
        .i_addr   (i_fault_addr)
    );

    // R1
    misalign_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[0] && acc_size != 2'd0)
        |-> (res_code == RC_D_MISALIGN || res_code == RC_I_MISALIGN));

    // R7
    sys_fetch_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_inst && acc_addr >= SYS_BASE && !misalign
         && nhits < 2 && !(en_sel && pfail_sel))
        |-> res_code == RC_I_MISS);

    // R11
    hwerr_nolog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code == RC_HWERR) |=> ($stable(d_fault_status) && $stable(d_fault_addr)));

    // R5
    idle_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> res_code == RC_OK);
endmodule

// File: tb/test_prot_lookup_checker.sv
module test_prot_lookup_checker;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0, cfg_side = 0;
    logic [1:0]  cfg_sel = 0;
    logic [3:0]  cfg_idx = 0;
    logic [31:0] cfg_wdata = 0;
    logic        acc_valid = 0, acc_write = 0, acc_inst = 0, acc_supv = 0, acc_sec = 0;
    logic [31:0] acc_addr = 0, acc_pc = 0;
    logic [1:0]  acc_size = 0;
    logic [3:0]  res_code;
    logic [31:0] d_fault_status, d_fault_addr, i_fault_status, i_fault_addr;

    prot_lookup_checker i_prot_lookup_checker (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    logic [31:0] mb [2][16];
    logic [31:0] ma [2][16];
    logic [31:0] mc [2];
    logic [31:0] e_ds, e_da, e_is, e_ia;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic side, input logic [1:0] sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_side = side; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = d;
        if (sel == 2'd0) mc[side] = d;
        if (sel == 2'd1) mb[side][idx] = d;
        if (sel == 2'd2) ma[side][idx] = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic [32:0] span_of(input logic [1:0] p);
        case (p)
            2'd0: return 33'h400;
            2'd1: return 33'h1000;
            2'd2: return 33'h100000;
            default: return 33'h400000;
        endcase
    endfunction

    task automatic acc(input string req, input logic [31:0] a, input logic [1:0] sz,
                       input logic w, input logic ins, input logic sv, input logic sc);
        logic [15:0] hm; int nh; logic pf; logic en; int k; logic [3:0] ec;
        logic [31:0] pc;
        logic sys, onc, cmb;
        pc = a ^ 32'h1357_9BDF;
        en = mc[ins][0]; hm = 0; pf = 0;
        for (int e = 0; e < 16; e++) begin
            logic [31:0] t; logic bad_e;
            t = ma[ins][e];
            if (en && t[0] && a >= mb[ins][e] && {1'b0, a} < {1'b0, mb[ins][e]} + span_of(t[17:16])) begin
                hm[e] = 1;
                if (w) bad_e = (!sv && !t[3]) || (sv && !t[4]) || (t[12] && !t[14] && !t[7]);
                else   bad_e = !sv && !t[2];
                if (bad_e) pf = 1;
            end
        end
        nh = $countones(hm);
        sys = a >= 32'hFFC0_0000; onc = a[31:24] == 8'hFF; cmb = a[31:20] == 12'hFFA;
        // k: 0 ok 1 miss 2 viol 3 mhit 4 misalign 5 hwerr
        if ((a & ((32'd1 << sz) - 1)) != 0) k = 4;
        else if (nh >= 2) k = 3;
        else if (pf) k = 2;
        else if (sys) k = ins ? 1 : ((!sv || sc) ? 2 : 0);
        else if (onc) k = ins ? (cmb ? 0 : 2) : (cmb ? 5 : 0);
        else k = (!en || nh == 1) ? 0 : 1;
        case (k)
            0: ec = 0; 1: ec = ins ? 5 : 1; 2: ec = ins ? 6 : 2;
            3: ec = ins ? 7 : 3; 4: ec = ins ? 8 : 4; default: ec = 9;
        endcase
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_size = sz; acc_write = w; acc_inst = ins;
        acc_supv = sv; acc_sec = sc; acc_pc = pc;
        #1;
        chk(req, 32'(res_code), 32'(ec));
        if (k != 0 && k != 5) begin
            if (ins) begin
                e_ia = a; e_is = {12'd0, k == 1, sc, sv, w, hm};
            end else begin
                e_da = a; e_ds = {12'd0, k == 1, sc, sv, w, hm};
                e_ia = pc; e_is = {14'd0, sv, 17'd0};
            end
        end
        @(posedge clk); #1;
        chk({req, "/R9 dstat"}, d_fault_status, e_ds);
        chk({req, "/R9 daddr"}, d_fault_addr, e_da);
        chk({req, "/R10 istat"}, i_fault_status, e_is);
        chk({req, "/R10 iaddr"}, i_fault_addr, e_ia);
        @(negedge clk); acc_valid = 0;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            mc[s] = 1;
            for (int e = 0; e < 16; e++) begin mb[s][e] = 0; ma[s][e] = 0; end
        end
        e_ds = 0; e_da = 0; e_is = 0; e_ia = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11 reset state
        chk("R11 reset", {res_code, d_fault_status[27:0]}, 0);
        chk("R11 reset", d_fault_addr | i_fault_addr | i_fault_status, 0);

        // R12 reset descriptors invalid: enabled, no hit -> miss
        acc("R12 empty", 32'h0000_1000, 2, 0, 0, 1, 0);
        acc("R5 empty inst", 32'h0000_2000, 2, 0, 1, 1, 0);

        // R1 alignment sweep with descriptors disabled
        cfg(0, 0, 0, 0); cfg(1, 0, 0, 0);
        for (int s = 0; s < 2; s++)
            for (int sz = 0; sz < 4; sz++)
                for (int lo = 0; lo < 8; lo++)
                    acc("R1 align", 32'h0010_0000 + 32'(lo), 2'(sz), 0, s[0], 1, 0);

        // R6 disabled: regions still apply
        acc("R6 sys fetch", 32'hFFC0_0100, 2, 0, 1, 1, 0);
        acc("R6 code data", 32'hFFA0_0010, 2, 0, 0, 1, 0);
        acc("R6 plain", 32'h2000_0000, 2, 1, 0, 0, 0);

        // R12 cfg_sel 3 ignored: control unchanged (still disabled)
        cfg(0, 3, 0, 32'h1);
        acc("R12 sel3", 32'h3000_0000, 2, 0, 0, 1, 0);
        cfg(0, 0, 0, 1); cfg(1, 0, 0, 1);

        // R2 page spans, edges
        for (int p = 0; p < 4; p++) begin
            logic [31:0] b; logic [31:0] sp;
            b = 32'h0100_0000 * 32'(p + 1);
            sp = 32'(span_of(2'(p)));
            cfg(0, 1, p, b); cfg(0, 2, p, 32'h1D | (32'(p) << 16));
            acc("R2 below", b - 4, 2, 0, 0, 0, 0);
            acc("R2 base",  b, 2, 0, 0, 0, 0);
            acc("R2 last",  b + sp - 4, 2, 0, 0, 0, 0);
            acc("R2 past",  b + sp, 2, 0, 0, 0, 0);
        end

        // R3 R4 permission sweep, both sides
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 64; c++) begin
                logic [31:0] at;
                at = 32'h1 | (32'(c[0]) << 2) | (32'(c[1]) << 3) | (32'(c[2]) << 4)
                   | (32'(c[3]) << 7) | (32'(c[4]) << 12) | (32'(c[5]) << 14);
                cfg(s[0], 2, 9, at); cfg(s[0], 1, 9, 32'h4000_0000);
                for (int m = 0; m < 4; m++)
                    acc(m[0] ? "R3 write" : "R4 read", 32'h4000_0040, 2, m[0], s[0], m[1], 0);
            end

        // R5 overlapping entries -> multiple hit, mask in status
        cfg(0, 1, 5, 32'h4000_0000); cfg(0, 2, 5, 32'h0002_001D);
        acc("R5 mhit", 32'h4000_0080, 2, 0, 0, 1, 1);
        acc("R5 mhit wr", 32'h4000_0200, 3, 1, 0, 0, 0);
        cfg(1, 1, 5, 32'h4000_0000); cfg(1, 2, 5, 32'h0003_001D);
        acc("R5 mhit inst", 32'h4000_0100, 2, 0, 1, 1, 0);

        // R7 R8 region rules with descriptors enabled and no match
        for (int sv = 0; sv < 2; sv++)
            for (int sc = 0; sc < 2; sc++) begin
                acc("R7 sys data", 32'hFFE0_0000, 2, 0, 0, sv[0], sc[0]);
                acc("R7 sys fetch", 32'hFFE0_0000, 2, 0, 1, sv[0], sc[0]);
            end
        acc("R8 code fetch", 32'hFFA0_0100, 2, 0, 1, 0, 0);
        acc("R8 other fetch", 32'hFF80_0100, 2, 0, 1, 0, 0);
        acc("R8 code data", 32'hFFA0_0100, 2, 0, 0, 1, 0);
        acc("R8 other data", 32'hFF80_0100, 2, 1, 0, 0, 0);
        acc("R8 data miss after", 32'h5000_0000, 2, 0, 0, 0, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule